// File: doc/BRIEF.md
# I2C Transaction CRC-8 Engine

This block sits next to the byte shifter of an I2C target and adds an optional CRC-8 to each transaction. It does no bit-level SCL/SDA handling. The target gives it four kinds of framing information: a strobe for every byte that crosses the bus, the START and STOP events, a flag that marks a byte as header, and the transfer direction. A header byte is a target address or the command byte that selects a register.

The first CRC of a transaction covers every byte seen since the START. That includes the write address, the command, any repeated-start address and the first data byte. Each CRC after that covers only the single data byte that comes before it. The byte that follows each data byte is a CRC slot. On a read, the block presents the CRC for the target to shift out. On a write, it compares the byte the controller sent with its own value and pulses an error on a mismatch, so that the target can discard the pending write. One configuration input turns the whole feature off. When it is off, the bus carries plain bytes only.

Top module: `i2c_crc8_engine`

## Requirements
- R1: The CRC is CRC-8 with generator 0x07. It starts from 0x00, takes each byte MSB first, and uses no reflection and no final XOR. A lone byte 0x0B yields 0x31.
- R2: The first CRC of a transaction covers every byte strobed since the START, header bytes included. The bytes 0x10, 0x14, 0x11, 0xC5 yield 0x79, and the bytes 0x10, 0x3E, 0x22 yield 0x63.
- R3: A byte strobed with `byte_hdr`=1 is folded into the CRC but opens no CRC slot, so `crc_tx_vld` stays low after it.
- R4: After a data byte (`byte_hdr`=0), the next strobed byte is a CRC slot. If the data byte was a read (`xfer_read`=1), `crc_tx_vld` is high from the cycle after its strobe until the cycle after the slot strobe, and `crc_tx` holds the CRC steady during that time. A write data byte never raises `crc_tx_vld`.
- R5: When a CRC slot completes, the accumulator reloads to 0x00, so that each later CRC covers only its own data byte. A data byte of 0x00 yields 0x00.
- R6: In a write CRC slot, the block compares the received byte with the computed CRC. On a mismatch, `crc_fail` is high for exactly the one cycle after the slot strobe. A match gives no pulse.
- R7: A START with no transaction open clears the accumulator. A repeated START keeps it if no data byte has completed yet, and clears it otherwise.
- R8: After reset or a STOP, `crc_tx_vld` and `crc_fail` are low and the accumulator is clear.
- R9: While `cfg_crc_on`=0, no CRC slots occur, `crc_tx_vld` and `crc_fail` stay low, and the block returns to its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_crc_on | input | 1 | Enables the CRC feature |
| bus_start | input | 1 | One-cycle pulse on START or repeated START |
| bus_stop | input | 1 | One-cycle pulse on STOP |
| byte_stb | input | 1 | One-cycle strobe for each completed byte |
| byte_val | input | 8 | Value of the strobed byte |
| byte_hdr | input | 1 | High when the byte is an address or command byte |
| xfer_read | input | 1 | High when the strobed data byte is sent by the target |
| crc_tx | output | 8 | CRC byte for the target to send in a read CRC slot |
| crc_tx_vld | output | 1 | A read CRC slot is pending and `crc_tx` is valid |
| crc_fail | output | 1 | One-cycle pulse when a received write CRC does not match |

## Verification
The assertions check these rules on every cycle:
- the error is a single-cycle pulse, caused only by a strobe whose byte differed from the presented CRC;
- a read slot opens only after a read data byte;
- `crc_tx` stays steady while a slot waits;
- a STOP or a disabled feature silences both outputs.

What the CRC covers can only be shown by the bench's scenarios and its reference model. That includes the fixed vectors, the repeated START kept before data and cleared after it, and the per-byte reload after each slot.

// File: rtl/i2c_crc8_pkg.sv
package i2c_crc8_pkg;

    localparam int unsigned CRC_W        = 8;
    localparam logic [CRC_W-1:0] CRC_POLY_DEF = 8'h07;
    localparam logic [CRC_W-1:0] CRC_INIT_DEF = 8'h00;

    typedef enum logic {
        SLOT_DATA = 1'b0,
        SLOT_CRC  = 1'b1
    } slot_e;

    typedef struct packed {
        logic [CRC_W-1:0] acc;
        logic             first_done;
        logic             in_txn;
        logic             dir_rd;
        slot_e            slot;
    } frame_st_t;

    // A START clears the running CRC unless it is a repeat before any data.
    function automatic logic start_clears(input frame_st_t s);
        return !s.in_txn || s.first_done;
    endfunction

endpackage

// File: rtl/i2c_crc8_step.sv
// One byte through the CRC generator, MSB first, unrolled bit by bit.
module i2c_crc8_step #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] stage [0:W];

    assign stage[0] = crc_in;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic fb;
        assign fb = stage[i][W-1] ^ data_in[W-1-i];
        assign stage[i+1] = {stage[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[W];
endmodule

// File: rtl/i2c_crc_frame.sv
// Tracks transaction framing, the CRC slots and the running accumulator.
module i2c_crc_frame
    import i2c_crc8_pkg::*;
#(
    parameter logic [CRC_W-1:0] INIT = CRC_INIT_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_on,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             byte_stb,
    input  logic [CRC_W-1:0] byte_val,
    input  logic             byte_hdr,
    input  logic             xfer_read,
    input  logic [CRC_W-1:0] crc_nxt,
    output logic [CRC_W-1:0] acc_o,
    output logic             slot_crc_o,
    output logic             dir_rd_o,
    output logic             fail_o
);
    frame_st_t st;
    frame_st_t st_idle;

    always_comb begin
        st_idle            = '0;
        st_idle.acc        = INIT;
        st_idle.slot       = SLOT_DATA;
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg_on) begin
            st     <= st_idle;
            fail_o <= 1'b0;
        end else begin
            fail_o <= 1'b0;
            if (bus_stop) begin
                st <= st_idle;
            end else if (bus_start) begin
                st.in_txn <= 1'b1;
                st.slot   <= SLOT_DATA;
                if (start_clears(st)) begin
                    st.acc        <= INIT;
                    st.first_done <= 1'b0;
                end
            end else if (byte_stb) begin
                if (st.slot == SLOT_CRC) begin
                    if (!st.dir_rd && (byte_val != st.acc))
                        fail_o <= 1'b1;
                    st.acc  <= INIT;
                    st.slot <= SLOT_DATA;
                end else begin
                    st.acc <= crc_nxt;
                    if (!byte_hdr) begin
                        st.slot       <= SLOT_CRC;
                        st.first_done <= 1'b1;
                        st.dir_rd     <= xfer_read;
                    end
                end
            end
        end
    end

    assign acc_o      = st.acc;
    assign slot_crc_o = (st.slot == SLOT_CRC);
    assign dir_rd_o   = st.dir_rd;
endmodule

// File: rtl/i2c_crc8_engine.sv
module i2c_crc8_engine
    import i2c_crc8_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_POLY_DEF,
    parameter logic [CRC_W-1:0] INIT = CRC_INIT_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_crc_on,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             byte_stb,
    input  logic [CRC_W-1:0] byte_val,
    input  logic             byte_hdr,
    input  logic             xfer_read,
    output logic [CRC_W-1:0] crc_tx,
    output logic             crc_tx_vld,
    output logic             crc_fail
);
    logic [CRC_W-1:0] acc;
    logic [CRC_W-1:0] crc_nxt;
    logic             slot_crc;
    logic             dir_rd;

    i2c_crc8_step #(.W(CRC_W), .POLY(POLY)) u_step (
        .crc_in  (acc),
        .data_in (byte_val),
        .crc_out (crc_nxt)
    );

    i2c_crc_frame #(.INIT(INIT)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .cfg_on     (cfg_crc_on),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .byte_stb   (byte_stb),
        .byte_val   (byte_val),
        .byte_hdr   (byte_hdr),
        .xfer_read  (xfer_read),
        .crc_nxt    (crc_nxt),
        .acc_o      (acc),
        .slot_crc_o (slot_crc),
        .dir_rd_o   (dir_rd),
        .fail_o     (crc_fail)
    );

    assign crc_tx     = acc;
    assign crc_tx_vld = slot_crc && dir_rd;
endmodule

// File: rtl/i2c_crc8_engine_chk.sv
module i2c_crc8_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_crc_on,
    input logic       bus_start,
    input logic       bus_stop,
    input logic       byte_stb,
    input logic [7:0] byte_val,
    input logic       byte_hdr,
    input logic       xfer_read,
    input logic [7:0] crc_tx,
    input logic       crc_tx_vld,
    input logic       crc_fail
);
    a_r6_fail_one_cycle: assert property (@(posedge clk) disable iff (rst)
        crc_fail |=> !crc_fail);

    a_r6_fail_cause: assert property (@(posedge clk) disable iff (rst)
        crc_fail |-> $past(byte_stb) && $past(cfg_crc_on) && !$past(bus_start)
                     && !$past(bus_stop) && ($past(byte_val) != $past(crc_tx)));

    a_r4_slot_source: assert property (@(posedge clk) disable iff (rst)
        $rose(crc_tx_vld) |-> $past(byte_stb) && !$past(byte_hdr) && $past(xfer_read));

    a_r4_tx_steady: assert property (@(posedge clk) disable iff (rst)
        (crc_tx_vld && !byte_stb && !bus_start && !bus_stop && cfg_crc_on)
            |=> crc_tx_vld && $stable(crc_tx));

    a_r8_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> !crc_tx_vld && !crc_fail);

    a_r9_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !cfg_crc_on |=> !crc_tx_vld && !crc_fail);
endmodule

bind i2c_crc8_engine i2c_crc8_engine_chk u_chk (.*);

// File: tb/sim_i2c_crc8_engine.sv
`timescale 1ns/1ps
module sim_i2c_crc8_engine;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_crc_on = 1'b1;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       byte_stb = 1'b0;
    logic [7:0] byte_val = 8'h00;
    logic       byte_hdr = 1'b0;
    logic       xfer_read = 1'b0;
    logic [7:0] crc_tx;
    logic       crc_tx_vld;
    logic       crc_fail;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    i2c_crc8_engine u0 (.*);

    // Behavioural reference: byte list since last clear, folded on demand.
    int  q_bytes[$];
    bit  m_intxn, m_first, m_slot, m_rd, m_fail;

    function automatic int ref_crc(input int bytes[$]);
        int c = 0;
        foreach (bytes[k]) begin
            c = c ^ bytes[k];
            for (int b = 0; b < 8; b++)
                c = (c & 128) != 0 ? ((c << 1) ^ 7) & 255 : (c << 1) & 255;
        end
        return c;
    endfunction

    always @(posedge clk) begin
        m_fail = 0;
        if (rst || !cfg_crc_on || bus_stop) begin
            q_bytes.delete(); m_intxn = 0; m_first = 0; m_slot = 0; m_rd = 0;
        end else if (bus_start) begin
            if (!m_intxn || m_first) begin q_bytes.delete(); m_first = 0; end
            m_intxn = 1; m_slot = 0;
        end else if (byte_stb) begin
            if (m_slot) begin
                if (!m_rd && int'(byte_val) != ref_crc(q_bytes)) m_fail = 1;
                q_bytes.delete(); m_slot = 0;
            end else begin
                q_bytes.push_back(int'(byte_val));
                if (!byte_hdr) begin m_slot = 1; m_first = 1; m_rd = xfer_read; end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R4 vld model", int'(crc_tx_vld), int'(m_slot && m_rd));
            if (m_slot && m_rd) chk("R4 value model", int'(crc_tx), ref_crc(q_bytes));
            chk("R6 fail model", int'(crc_fail), int'(m_fail));
        end
    end

    task automatic tick(); @(negedge clk); endtask
    task automatic do_start(); bus_start = 1; tick(); bus_start = 0; endtask
    task automatic do_stop();  bus_stop = 1;  tick(); bus_stop = 0;  endtask
    task automatic put(input logic [7:0] v, input logic hdr, input logic rd);
        byte_val = v; byte_hdr = hdr; xfer_read = rd; byte_stb = 1;
        tick();
        byte_stb = 0; byte_hdr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        chk("R8 reset vld", int'(crc_tx_vld), 0);
        chk("R8 reset fail", int'(crc_fail), 0);

        // Read with repeated START before data (R2, R3, R7 keep)
        do_start();
        put(8'h10, 1, 0);
        chk("R3 hdr no slot", int'(crc_tx_vld), 0);
        put(8'h14, 1, 0);
        do_start();
        put(8'h11, 1, 1);
        chk("R3 hdr no slot rd", int'(crc_tx_vld), 0);
        put(8'hC5, 0, 1);
        chk("R2 vld", int'(crc_tx_vld), 1);
        chk("R2 first crc 0x79 R7 kept", int'(crc_tx), 8'h79);
        tick(); tick();
        chk("R4 held", int'(crc_tx), 8'h79);
        put(8'h79, 0, 1);
        chk("R4 slot closes", int'(crc_tx_vld), 0);
        put(8'h0B, 0, 1);
        chk("R5 lone 0x0B gives 0x31 (R1)", int'(crc_tx), 8'h31);
        put(8'h31, 0, 1);
        do_stop();
        chk("R8 stop vld", int'(crc_tx_vld), 0);

        // Write sequence (R2, R5, R6)
        do_start();
        put(8'h10, 1, 0);
        put(8'h3E, 1, 0);
        put(8'h22, 0, 0);
        chk("R4 write no tx", int'(crc_tx_vld), 0);
        put(8'h63, 0, 0);
        chk("R2 write crc 0x63 match", int'(crc_fail), 0);
        put(8'h00, 0, 0);
        put(8'h00, 0, 0);
        chk("R5 lone 0x00 match", int'(crc_fail), 0);
        put(8'h0B, 0, 0);
        put(8'h12, 0, 0);
        chk("R6 mismatch pulse", int'(crc_fail), 1);
        tick();
        chk("R6 pulse one cycle", int'(crc_fail), 0);
        put(8'h0B, 0, 0);
        put(8'h31, 0, 0);
        chk("R6 match no pulse", int'(crc_fail), 0);
        do_stop();

        // Repeated START after data clears (R7)
        do_start();
        put(8'h10, 1, 1);
        put(8'hC5, 0, 1);
        put(8'h00, 0, 1);
        do_start();
        put(8'h0B, 0, 1);
        chk("R7 restart after data clears", int'(crc_tx), 8'h31);
        put(8'h31, 0, 1);
        do_stop();

        // Fresh START with one data byte (R1)
        do_start();
        put(8'h0B, 0, 1);
        chk("R1 single byte", int'(crc_tx), 8'h31);
        do_stop();

        // Disabled (R9)
        cfg_crc_on = 0;
        do_start();
        put(8'h10, 1, 1);
        put(8'hC5, 0, 1);
        chk("R9 off no tx", int'(crc_tx_vld), 0);
        put(8'h22, 0, 0);
        put(8'h99, 0, 0);
        chk("R9 off no fail", int'(crc_fail), 0);
        do_stop();
        cfg_crc_on = 1;
        tick();
        do_start();
        put(8'h10, 1, 0);
        put(8'h3E, 1, 0);
        put(8'h22, 0, 1);
        chk("R9 re-enable clean", int'(crc_tx), 8'h63);
        do_stop();
        tick();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule